// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register transactions to an Ethernet PHY over the two-wire management interface. It uses the short frame format: one PHY address and one register address of five bits each, and a 16-bit data field. A client starts a transaction by pulsing a request together with:

- a read/write flag,
- the PHY and register addresses,
- for writes, the data word.

The block then sequences the whole serial frame without further help. It makes the management clock from the system clock. Each half-period of that clock lasts a parameterised number of system cycles. The block drives the data line through a data bit and an output-enable, meant for an external tri-state pad.

During a read, the block releases the line for the turnaround and samples the bit that the PHY should pull low. If no PHY answers, the line stays high. The block then gives the bus 32 clocks of recovery with the line released. It completes with all-ones data and the error flag set. On every completion the block pulses `done` for one cycle, and `busy` spans the transaction.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no transaction is running, `mdc` is high, `mdio_oe` is low and `busy` is low; `done` and `err` are low after reset.
- R2: Every frame begins with 32 clock periods driving 1. Next come the start bits 0 then 1 and the operation code: 1,0 for a read or 0,1 for a write. The PHY address and then the register address follow, each sent most significant bit first.
- R3: Each `mdc` high phase and low phase lasts exactly DIV_HALF system clock cycles. `mdio_o` and `mdio_oe` change only while `mdc` is low (when the low phase begins), so they are stable across each rising edge and the whole high phase.
- R4: A write drives the turnaround bits 1 then 0, then the 16 data bits, most significant first. It then releases the line (`mdio_oe` low) for one more `mdc` period. That gives 65 rising edges, 64 of them with the line driven.
- R5: A read drives only the first 46 bits. It releases the line from the first turnaround period on. It samples the turnaround at the end of that period's high phase. If the turnaround is 0, it samples 16 data bits, most significant first, at the end of the next 16 high phases. One idle period follows (64 rising edges in total). The read then completes with `rdata` equal to the sampled word and `err` low.
- R6: If the sampled turnaround bit is 1, the block issues 32 further `mdc` periods with the line released (79 rising edges in total). It then completes with `rdata` = 0xFFFF and `err` high.
- R7: `done` is a one-cycle pulse in the cycle where `busy` falls. `err` and `rdata` are valid from that cycle and are held until the next completion.
- R8: `busy` rises in the cycle after an accepted request. A request presented while `busy` is high is ignored: the running frame is unaffected and no further transaction follows.
- R9: A write completion leaves `rdata` unchanged and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completion found no PHY |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value to drive on the line |
| mdio_oe | output | 1 | Drive enable for the line |
| mdio_i | input | 1 | Sampled line value |

## Verification
A PHY model in the bench records every bit driven at each rising clock edge. It answers reads with a chosen turnaround level and data word. The model also measures the length of every clock phase.

Writes use all-ones, all-zeros and alternating data with extreme addresses, which separates bit order and opcode errors. Reads use words whose set bits sit only at the two ends, which exposes an off-by-one in the sampling point. A read with a missing PHY shows whether the recovery path, the forced all-ones data and the error flag were taken. A present read that follows it shows that the error clears. A request injected mid-frame shows whether the busy guard really holds off a second transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int MDIO_AW      = 5;
    localparam int MDIO_DW      = 16;
    localparam int MDIO_PRE     = 32;
    localparam int MDIO_RECOVER = 32;

    // header = preamble + start(2) + opcode(2) + two addresses
    localparam int HDR_BITS  = MDIO_PRE + 4 + 2 * MDIO_AW;
    localparam int FRAME_W   = HDR_BITS + 2 + MDIO_DW;
    localparam int SLOT_W    = $clog2(FRAME_W + MDIO_RECOVER + 1);
    localparam int TA_SLOT   = HDR_BITS;
    localparam int RD_LAST   = HDR_BITS + MDIO_DW + 1;
    localparam int WR_LAST   = FRAME_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_RECOVER = 2'd2
    } mdio_state_e;

    typedef struct packed {
        mdio_state_e           state;
        logic                  mdc;
        logic                  oe;
        logic                  is_read;
        logic [SLOT_W-1:0]     slot;
        logic [FRAME_W-1:0]    tx;
        logic [MDIO_DW-1:0]    rx;
        logic [MDIO_DW-1:0]    rdata;
        logic                  err;
        logic                  done;
    } mdio_regs_t;

endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
    parameter int DIV_HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CNT_LAST);
        cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
    import mdio_pkg::*;
(
    input  logic               rd,
    input  logic [MDIO_AW-1:0] phy,
    input  logic [MDIO_AW-1:0] regad,
    input  logic [MDIO_DW-1:0] wdata,
    output logic [FRAME_W-1:0] frame
);
    logic [1:0]         opcode;
    logic [MDIO_DW-1:0] payload;

    always_comb begin
        opcode  = rd ? 2'b10 : 2'b01;
        payload = rd ? '0 : wdata;
        frame   = {{MDIO_PRE{1'b1}}, 2'b01, opcode, phy, regad, 2'b10, payload};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_read,
    input  logic [MDIO_AW-1:0] req_phy,
    input  logic [MDIO_AW-1:0] req_reg,
    input  logic [MDIO_DW-1:0] req_wdata,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [MDIO_DW-1:0] rdata,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    localparam logic [SLOT_W-1:0] TA_S      = SLOT_W'(TA_SLOT);
    localparam logic [SLOT_W-1:0] RD_LAST_S = SLOT_W'(RD_LAST);
    localparam logic [SLOT_W-1:0] WR_LAST_S = SLOT_W'(WR_LAST);
    localparam logic [SLOT_W-1:0] HDR_S     = SLOT_W'(HDR_BITS);
    localparam logic [SLOT_W-1:0] FRAME_S   = SLOT_W'(FRAME_W);
    localparam logic [SLOT_W-1:0] DLAST_S   = SLOT_W'(TA_SLOT + MDIO_DW);
    localparam logic [SLOT_W-1:0] REC_LAST  = SLOT_W'(MDIO_RECOVER - 1);

    mdio_regs_t         r_d, r_q;
    logic               tick;
    logic               run;
    logic [FRAME_W-1:0] frame;
    logic [SLOT_W-1:0]  last_slot;
    logic [SLOT_W-1:0]  nxt_slot;

    assign run = (r_q.state != ST_IDLE);

    mdio_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    mdio_frame_build u_frame (
        .rd    (req_read),
        .phy   (req_phy),
        .regad (req_reg),
        .wdata (req_wdata),
        .frame (frame)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        last_slot = r_q.is_read ? RD_LAST_S : WR_LAST_S;
        nxt_slot  = r_q.slot + SLOT_W'(1);
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state   = ST_RUN;
                    r_d.mdc     = 1'b0;
                    r_d.oe      = 1'b1;
                    r_d.is_read = req_read;
                    r_d.slot    = '0;
                    r_d.tx      = frame;
                    r_d.rx      = '0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!r_q.mdc) begin
                        r_d.mdc = 1'b1;
                    end else if (r_q.is_read && (r_q.slot == TA_S) && mdio_i) begin
                        // nobody pulled the turnaround low
                        r_d.state = ST_RECOVER;
                        r_d.slot  = '0;
                        r_d.mdc   = 1'b0;
                        r_d.oe    = 1'b0;
                        r_d.tx    = '0;
                    end else if (r_q.slot == last_slot) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.oe    = 1'b0;
                        if (r_q.is_read) r_d.rdata = r_q.rx;
                    end else begin
                        if (r_q.is_read && (r_q.slot > TA_S) && (r_q.slot <= DLAST_S))
                            r_d.rx = {r_q.rx[MDIO_DW-2:0], mdio_i};
                        r_d.slot = nxt_slot;
                        r_d.mdc  = 1'b0;
                        r_d.tx   = {r_q.tx[FRAME_W-2:0], 1'b0};
                        r_d.oe   = r_q.is_read ? (nxt_slot < HDR_S) : (nxt_slot < FRAME_S);
                    end
                end
            end
            ST_RECOVER: begin
                if (tick) begin
                    if (!r_q.mdc) begin
                        r_d.mdc = 1'b1;
                    end else if (r_q.slot == REC_LAST) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.rdata = '1;
                    end else begin
                        r_d.slot = nxt_slot;
                        r_d.mdc  = 1'b0;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.mdc   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = run;
    assign done    = r_q.done;
    assign err     = r_q.err;
    assign rdata   = r_q.rdata;
    assign mdc     = r_q.mdc;
    assign mdio_oe = r_q.oe;
    assign mdio_o  = r_q.oe & r_q.tx[FRAME_W-1];
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [MDIO_DW-1:0] rdata,
    input logic               mdc,
    input logic               mdio_o,
    input logic               mdio_oe
);
    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mdc && !mdio_oe));

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    absent_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rdata == '1));

    // R8
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $rose(busy));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .rdata   (rdata),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int DIV = 4;
    localparam int NV  = 7;
    // {read, phy present, phy addr, reg addr, data}
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 1'b1, 5'h01, 5'h00, 16'hA5C3},
        {1'b1, 1'b1, 5'h01, 5'h02, 16'h3C5A},
        {1'b1, 1'b0, 5'h1F, 5'h1F, 16'h0000},
        {1'b1, 1'b1, 5'h10, 5'h01, 16'h8001},
        {1'b0, 1'b1, 5'h1F, 5'h1F, 16'hFFFF},
        {1'b0, 1'b1, 5'h00, 5'h10, 16'h0000},
        {1'b1, 1'b1, 5'h00, 5'h00, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0;
    logic [4:0] req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic mdio_i;

    always #5 clk = ~clk;

    mdio_master #(.DIV_HALF(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int tests = 0, fails = 0, cyc = 0;

    // PHY model settings (written by the stimulus process only)
    logic        m_read = 1'b0, m_present = 1'b1;
    logic [15:0] m_data = '0;

    // monitor state (written by the monitor only)
    logic        prev_mdc = 1'b1, prev_busy = 1'b0, have_edge = 1'b0;
    int          gap = 0, rises = 0, ndrv = 0, bad_gap = 0;
    logic [63:0] cap = '0;
    logic        line = 1'b1;
    assign mdio_i = line;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (busy && !prev_busy) begin
            rises = 0; ndrv = 0; bad_gap = 0; cap = '0; have_edge = 1'b0; gap = 0;
        end
        if (busy) begin
            gap = gap + 1;
            if (mdc != prev_mdc) begin
                if (have_edge && gap != DIV) bad_gap = bad_gap + 1;
                have_edge = 1'b1;
                gap = 0;
                if (mdc) begin
                    rises = rises + 1;
                    if (mdio_oe) begin
                        ndrv = ndrv + 1;
                        cap  = {cap[62:0], mdio_o};
                    end
                    line = 1'b1;
                    if (m_read && rises - 1 == 46) line = !m_present;
                    else if (m_read && m_present && rises - 1 >= 47 && rises - 1 <= 62)
                        line = m_data[15 - (rises - 1 - 47)];
                end
            end
        end else begin
            line = 1'b1;
        end
        prev_mdc  = mdc;
        prev_busy = busy;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] frame_of(input logic rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, (rd ? 16'h0 : d)};
    endfunction

    task automatic start(input logic rd, input logic pres, input logic [4:0] p,
                         input logic [4:0] r, input logic [15:0] d);
        m_read = rd; m_present = pres; m_data = d;
        req_valid = 1'b1; req_read = rd; req_phy = p; req_reg = r; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "busy after accept", 64'(busy), 64'd1);
    endtask

    task automatic finish_wait();
        int t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk("R7", "done seen", 64'(done), 64'd1);
        chk("R7", "busy low with done", 64'(busy), 64'd0);
    endtask

    logic [15:0] last_rd = 16'h0000;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "mdc idle", 64'(mdc), 64'd1);
        chk("R1", "oe idle", 64'(mdio_oe), 64'd0);
        chk("R1", "busy idle", 64'(busy), 64'd0);
        chk("R1", "done/err idle", {62'd0, done, err}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "mdc after reset", {62'd0, mdc, mdio_oe}, 64'd2);

        for (int i = 0; i < NV; i++) begin
            logic rd, pres;
            logic [4:0] p, r;
            logic [15:0] d;
            logic [63:0] ef;
            {rd, pres, p, r, d} = VEC[i];
            ef = frame_of(rd, p, r, d);
            start(rd, pres, p, r, d);
            finish_wait();
            chk("R3", "phase length", 64'(bad_gap), 64'd0);
            if (!rd) begin
                chk("R2", "write frame", cap, ef);
                chk("R4", "write rises", 64'(rises), 64'd65);
                chk("R4", "write driven bits", 64'(ndrv), 64'd64);
                chk("R9", "write keeps rdata", 64'(rdata), 64'(last_rd));
                chk("R9", "write clears err", 64'(err), 64'd0);
            end else begin
                chk("R2", "read header", {18'd0, cap[45:0]}, {18'd0, ef[63:18]});
                chk("R5", "read driven bits", 64'(ndrv), 64'd46);
                if (pres) begin
                    chk("R5", "read rises", 64'(rises), 64'd64);
                    chk("R5", "read data", 64'(rdata), 64'(d));
                    chk("R5", "read err", 64'(err), 64'd0);
                    last_rd = d;
                end else begin
                    chk("R6", "absent rises", 64'(rises), 64'd79);
                    chk("R6", "absent data", 64'(rdata), 64'hFFFF);
                    chk("R6", "absent err", 64'(err), 64'd1);
                    last_rd = 16'hFFFF;
                end
            end
            @(negedge clk);
            chk("R7", "done one cycle", 64'(done), 64'd0);
            chk("R7", "err held", 64'(err), 64'(rd && !pres));
            chk("R1", "idle after done", {62'd0, mdc, mdio_oe}, 64'd2);
            repeat (5) @(negedge clk);
        end

        // R8: a request during a running write must be ignored
        start(1'b0, 1'b1, 5'h0A, 5'h15, 16'h5A0F);
        repeat (100) @(negedge clk);
        req_valid = 1'b1; req_read = 1'b1; req_phy = 5'h11; req_reg = 5'h04;
        @(negedge clk);
        req_valid = 1'b0;
        finish_wait();
        chk("R8", "frame unaffected", cap, frame_of(1'b0, 5'h0A, 5'h15, 16'h5A0F));
        chk("R8", "rises unaffected", 64'(rises), 64'd65);
        repeat (30) @(negedge clk);
        chk("R8", "no second transaction", 64'(busy), 64'd0);
        chk("R9", "rdata after write", 64'(rdata), 64'(last_rd));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule